// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block is the host side of a three-wire link to a 12-, 10- or 8-bit successive-approximation converter that has no command port. The converter takes its sample when chip select falls and shifts a 16-bit word out on the falling edges of the serial clock. It enters or leaves its low-power state only according to when chip select is released. The sequencer runs on the system clock. It divides that clock down to the serial clock, frames every conversion, samples the data line and hands back a right-aligned parallel sample with a one-cycle strobe.

The converter's power state is not visible from the host, so the sequencer tracks it. After reset, and after every deliberate shutdown, it spends one full-length frame waking the converter and discards that result. In the power-saving mode each burst has three frames: a wake frame, a frame that is reported, and a frame cut short on purpose, which puts the converter into shutdown. The sequencer then waits for a programmed interval before the next burst. In the continuous mode it reads frames back to back, with only the quiet gap between them. A valid/ready request carries the mode, the resolution and the interval. The serial clock ratio and the quiet gap are derived from the system clock frequency given as a parameter.

Top module: `adc_seq_master`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select is high, the serial clock is low, the sample strobe is low and the request port is ready.
- R2: Every high and every low phase of the serial clock lasts exactly HALF system cycles, with HALF = ceil(CLK_MHZ / (2*SCLK_MHZ)). The serial clock stays low while chip select is high, so the first edge after chip select falls is a rising edge, HALF cycles later.
- R3: A full frame has 16 falling serial clock edges. One data bit is captured at each falling edge, first bit first. The first captured bit is the most significant bit of the 16-bit word.
- R4: Between two frames chip select stays high for at least QUIET_CYC = ceil(CLK_MHZ*QUIET_NS/1000) system cycles.
- R5: The first frame after reset, and the first frame after any shutdown, is a full 16-edge frame whose result is never reported.
- R6: In power-saving mode (req_mode = 1) each burst is a wake frame, a reported frame, and then a shutdown frame. The shutdown frame releases chip select at the SD_FALLS-th falling edge (2 < SD_FALLS < 10).
- R7: After a shutdown frame, chip select stays high for at least QUIET_CYC plus the programmed interval (req_ivl) in system cycles.
- R8: In continuous mode (req_mode = 0) every full frame after the wake frame produces one sample. smp_valid is a single-cycle pulse that is only raised while chip select is high.
- R9: The field follows the 16-bit word w. For req_res 0, smp_data = w[11:0]. For req_res 1, smp_data = w[11:2]. For req_res 2, smp_data = w[11:4]. Narrower results are zero-extended. req_res 3 behaves like 0.
- R10: smp_err is raised with a sample exactly when any of w[15:12] is 1. The data field is still reported.
- R11: A request is taken when req_valid and req_ready are both high. req_ready is low whenever chip select is low.
- R12: No frame starts before the first request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 1 | 0 continuous, 1 power-saving |
| req_res | input | 2 | Resolution select (see R9) |
| req_ivl | input | IVL_W | Extra idle cycles after a shutdown frame |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_sdata | input | 1 | Converter serial data |
| smp_valid | output | 1 | Sample strobe, one cycle |
| smp_data | output | 12 | Right-aligned sample |
| smp_err | output | 1 | Leading bits of the frame were not zero |

## Verification
A wrong power-state record shows up on the serial pins within one burst. A skipped wake frame makes the converter's garbage word (all ones) appear at smp_data with smp_err set, two frames after the mistake. A missing shutdown shows as a burst with only full-length frames. A miscounted divider or edge counter changes the phase length or frame length at once and is caught on the very frame it affects. A wrong field selection is caught on the first sample reported at that resolution.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int FRAME_BITS = 16;
   localparam int LEAD_BITS  = 4;
   localparam int DATA_W     = 12;

   typedef enum logic [1:0] {
      RES_12  = 2'd0,
      RES_10  = 2'd1,
      RES_8   = 2'd2,
      RES_12B = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      FK_DUMMY = 2'd0,
      FK_VALID = 2'd1,
      FK_SHDN  = 2'd2
   } fkind_e;

   // system cycles per serial clock phase (rounded up, at least one)
   function automatic int calc_half(input int clk_mhz, input int sclk_mhz);
      int h;
      h = (clk_mhz + 2 * sclk_mhz - 1) / (2 * sclk_mhz);
      return (h < 1) ? 1 : h;
   endfunction

   // system cycles covering the quiet time in ns (rounded up, at least one)
   function automatic int calc_quiet(input int clk_mhz, input int quiet_ns);
      int q;
      q = (clk_mhz * quiet_ns + 999) / 1000;
      return (q < 1) ? 1 : q;
   endfunction
endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
   import adc_seq_pkg::*;
#(
   parameter int HALF     = 3,
   parameter int SD_FALLS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  short_frame,
   input  logic                  sdata,
   output logic                  cs_n,
   output logic                  sclk,
   output logic                  done,
   output logic [FRAME_BITS-1:0] word
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int FW = $clog2(FRAME_BITS + 1);

   typedef enum logic [1:0] {FE_IDLE, FE_SETUP, FE_HI, FE_LO} fe_st_e;

   fe_st_e          st;
   logic [HW-1:0]   ph_cnt;
   logic [FW-1:0]   falls;
   logic [FW-1:0]   target;
   logic [FW-1:0]   falls_nx;
   logic            phase_end;

   assign phase_end = (ph_cnt == HW'(HALF - 1));
   assign falls_nx  = falls + FW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FE_IDLE;
         ph_cnt <= '0;
         falls  <= '0;
         target <= '0;
         cs_n   <= 1'b1;
         sclk   <= 1'b0;
         done   <= 1'b0;
         word   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            FE_IDLE: begin
               if (start) begin
                  cs_n   <= 1'b0;
                  st     <= FE_SETUP;
                  ph_cnt <= '0;
                  falls  <= '0;
                  target <= short_frame ? FW'(SD_FALLS) : FW'(FRAME_BITS);
               end
            end
            FE_SETUP, FE_LO: begin
               if (phase_end) begin
                  sclk   <= 1'b1;
                  st     <= FE_HI;
                  ph_cnt <= '0;
               end else begin
                  ph_cnt <= ph_cnt + HW'(1);
               end
            end
            FE_HI: begin
               if (phase_end) begin
                  sclk   <= 1'b0;
                  ph_cnt <= '0;
                  word   <= {word[FRAME_BITS-2:0], sdata};
                  falls  <= falls_nx;
                  if (falls_nx == target) begin
                     cs_n <= 1'b1;
                     done <= 1'b1;
                     st   <= FE_IDLE;
                  end else begin
                     st <= FE_LO;
                  end
               end else begin
                  ph_cnt <= ph_cnt + HW'(1);
               end
            end
            default: st <= FE_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_field_extract.sv
module adc_field_extract
   import adc_seq_pkg::*;
#(
   parameter bit NARROW_EN = 1'b1
) (
   input  logic [FRAME_BITS-1:0] word,
   input  res_e                  res,
   output logic [DATA_W-1:0]     data,
   output logic                  lead_err
);
   localparam int BODY = FRAME_BITS - LEAD_BITS;

   logic [BODY-1:0] body;

   assign body     = word[BODY-1:0];
   assign lead_err = |word[FRAME_BITS-1 -: LEAD_BITS];

   generate
      if (NARROW_EN) begin : g_multi_res
         always_comb begin
            unique case (res)
               RES_10:  data = DATA_W'(body >> 2);
               RES_8:   data = DATA_W'(body >> 4);
               default: data = DATA_W'(body);
            endcase
         end
      end else begin : g_full_only
         assign data = DATA_W'(body);
      end
   endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int QUIET_CYC = 5,
   parameter int IVL_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_mode,
   input  logic [1:0]        req_res,
   input  logic [IVL_W-1:0]  req_ivl,
   output logic              req_ready,
   output logic              fe_start,
   output logic              fe_short,
   input  logic              fe_done,
   input  logic [DATA_W-1:0] ext_data,
   input  logic              ext_err,
   output res_e              res_sel,
   output logic              smp_valid,
   output logic [DATA_W-1:0] smp_data,
   output logic              smp_err
);
   localparam int QW = $clog2(QUIET_CYC + 1);
   localparam int GW = ((IVL_W > QW) ? IVL_W : QW) + 1;

   typedef enum logic [1:0] {C_OFF, C_GAP, C_RUN} c_st_e;

   c_st_e            st;
   logic             active;
   logic             cfg_save;
   logic [IVL_W-1:0] cfg_ivl;
   logic             need_dummy;
   logic             did_valid;
   fkind_e           kind;
   fkind_e           kind_nx;
   logic [GW-1:0]    gap_cnt;
   logic             accept;
   logic             issue;

   assign req_ready = (st != C_RUN);
   assign accept    = req_valid && req_ready;

   always_comb begin
      if (need_dummy)                 kind_nx = FK_DUMMY;
      else if (cfg_save && did_valid) kind_nx = FK_SHDN;
      else                            kind_nx = FK_VALID;
   end

   assign issue = ((st == C_OFF) && active) ||
                  ((st == C_GAP) && (gap_cnt <= GW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cfg_save <= 1'b0;
         res_sel  <= RES_12;
         cfg_ivl  <= '0;
      end else if (accept) begin
         active   <= 1'b1;
         cfg_save <= req_mode;
         res_sel  <= res_e'(req_res);
         cfg_ivl  <= req_ivl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= C_OFF;
         need_dummy <= 1'b1;
         did_valid  <= 1'b0;
         kind       <= FK_DUMMY;
         gap_cnt    <= '0;
         fe_start   <= 1'b0;
         fe_short   <= 1'b0;
         smp_valid  <= 1'b0;
         smp_data   <= '0;
         smp_err    <= 1'b0;
      end else begin
         fe_start  <= 1'b0;
         smp_valid <= 1'b0;
         if (issue) begin
            fe_start <= 1'b1;
            fe_short <= (kind_nx == FK_SHDN);
            kind     <= kind_nx;
            st       <= C_RUN;
         end else if (st == C_GAP) begin
            gap_cnt <= gap_cnt - GW'(1);
         end else if ((st == C_RUN) && fe_done) begin
            st      <= C_GAP;
            gap_cnt <= GW'(QUIET_CYC) + ((kind == FK_SHDN) ? GW'(cfg_ivl) : GW'(0));
            unique case (kind)
               FK_DUMMY: begin
                  need_dummy <= 1'b0;
                  did_valid  <= 1'b0;
               end
               FK_VALID: begin
                  did_valid <= 1'b1;
                  smp_valid <= 1'b1;
                  smp_data  <= ext_data;
                  smp_err   <= ext_err;
               end
               default: begin
                  need_dummy <= 1'b1;
                  did_valid  <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
   import adc_seq_pkg::*;
#(
   parameter int CLK_MHZ   = 100,
   parameter int SCLK_MHZ  = 20,
   parameter int QUIET_NS  = 50,
   parameter int SD_FALLS  = 4,
   parameter int IVL_W     = 16,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_mode,
   input  logic [1:0]        req_res,
   input  logic [IVL_W-1:0]  req_ivl,
   output logic              adc_cs_n,
   output logic              adc_sclk,
   input  logic              adc_sdata,
   output logic              smp_valid,
   output logic [DATA_W-1:0] smp_data,
   output logic              smp_err
);
   localparam int HALF      = calc_half(CLK_MHZ, SCLK_MHZ);
   localparam int QUIET_CYC = calc_quiet(CLK_MHZ, QUIET_NS);

   generate
      if (SD_FALLS < 3 || SD_FALLS > 9) begin : g_bad_sd
         $error("SD_FALLS must lie strictly between 2 and 10");
      end
      if (SCLK_MHZ < 1 || SCLK_MHZ > 20) begin : g_bad_sclk
         $error("SCLK_MHZ must be 1..20");
      end
      if (DATA_W != FRAME_BITS - LEAD_BITS) begin : g_bad_width
         $error("data width must match the frame body");
      end
   endgenerate

   logic                  fe_start;
   logic                  fe_short;
   logic                  fe_done;
   logic [FRAME_BITS-1:0] fe_word;
   logic [DATA_W-1:0]     ext_data;
   logic                  ext_err;
   res_e                  res_sel;

   adc_seq_ctrl #(
      .QUIET_CYC (QUIET_CYC),
      .IVL_W     (IVL_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_mode  (req_mode),
      .req_res   (req_res),
      .req_ivl   (req_ivl),
      .req_ready (req_ready),
      .fe_start  (fe_start),
      .fe_short  (fe_short),
      .fe_done   (fe_done),
      .ext_data  (ext_data),
      .ext_err   (ext_err),
      .res_sel   (res_sel),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .smp_err   (smp_err)
   );

   adc_frame_engine #(
      .HALF     (HALF),
      .SD_FALLS (SD_FALLS)
   ) frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (fe_start),
      .short_frame (fe_short),
      .sdata       (adc_sdata),
      .cs_n        (adc_cs_n),
      .sclk        (adc_sclk),
      .done        (fe_done),
      .word        (fe_word)
   );

   adc_field_extract #(
      .NARROW_EN (NARROW_EN)
   ) field_i (
      .word     (fe_word),
      .res      (res_sel),
      .data     (ext_data),
      .lead_err (ext_err)
   );
endmodule

// File: rtl/adc_seq_master_chk.sv
module adc_seq_master_chk
   import adc_seq_pkg::*;
#(
   parameter int CLK_MHZ  = 100,
   parameter int SCLK_MHZ = 20,
   parameter int QUIET_NS = 50,
   parameter int SD_FALLS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic adc_cs_n,
   input logic adc_sclk,
   input logic smp_valid
);
   localparam int HALF      = calc_half(CLK_MHZ, SCLK_MHZ);
   localparam int QUIET_CYC = calc_quiet(CLK_MHZ, QUIET_NS);

   logic [15:0] hi_len;
   logic [15:0] lo_len;
   logic [15:0] cs_hi;
   logic [4:0]  fcnt;
   logic        sclk_d;
   logic        seen_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len   <= '0;
         lo_len   <= '0;
         cs_hi    <= '0;
         fcnt     <= '0;
         sclk_d   <= 1'b0;
         seen_req <= 1'b0;
      end else begin
         sclk_d   <= adc_sclk;
         seen_req <= seen_req | (req_valid & req_ready);
         hi_len   <= adc_sclk ? hi_len + 16'd1 : 16'd0;
         lo_len   <= (!adc_sclk && !adc_cs_n) ? lo_len + 16'd1 : 16'd0;
         if (!adc_cs_n)              cs_hi <= '0;
         else if (cs_hi != 16'hFFFF) cs_hi <= cs_hi + 16'd1;
         if (adc_cs_n)                fcnt <= '0;
         else if (sclk_d && !adc_sclk) fcnt <= fcnt + 5'd1;
      end
   end

   p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk);

   p_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sclk) |-> (hi_len == 16'(HALF)));

   p_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_sclk) |-> (lo_len == 16'(HALF)));

   p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_sclk) && adc_cs_n) |-> ((fcnt == 5'd15) || (fcnt == 5'(SD_FALLS - 1))));

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> (cs_hi >= 16'(QUIET_CYC)));

   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);

   p_report_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> adc_cs_n);

   p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_cs_n |-> !req_ready);

   p_no_early_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_req |-> adc_cs_n);
endmodule

bind adc_seq_master adc_seq_master_chk #(
   .CLK_MHZ  (CLK_MHZ),
   .SCLK_MHZ (SCLK_MHZ),
   .QUIET_NS (QUIET_NS),
   .SD_FALLS (SD_FALLS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .adc_cs_n  (adc_cs_n),
   .adc_sclk  (adc_sclk),
   .smp_valid (smp_valid)
);

// File: tb/adc_seq_master_tb_top.sv
module adc_seq_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;   // ceil(100 / 40)
   localparam int QUIET      = 5;   // ceil(100 * 50 / 1000)
   localparam int IVL_W      = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_mode = 1'b0;
   logic [1:0]       req_res = 2'd0;
   logic [IVL_W-1:0] req_ivl = '0;
   logic             adc_cs_n;
   logic             adc_sclk;
   logic             adc_sdata = 1'b0;
   logic             smp_valid;
   logic [11:0]      smp_data;
   logic             smp_err;

   adc_seq_master dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_mode  (req_mode),
      .req_res   (req_res),
      .req_ivl   (req_ivl),
      .adc_cs_n  (adc_cs_n),
      .adc_sclk  (adc_sclk),
      .adc_sdata (adc_sdata),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .smp_err   (smp_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int errs = 0;
   int checks = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic [11:0] d;
      logic        e;
   } exp_t;
   exp_t sb_q[$];

   // converter model
   bit          awake = 1'b0;
   bit          awake_at_start = 1'b0;
   bit          in_rst = 1'b1;
   bit          inject = 1'b0;
   bit          last_short = 1'b0;
   int          falls = 0;
   int          cur_res = 0;
   int          cur_ivl = 0;
   int          sd_frames = 0;
   int          dummy_bad = 0;
   int          len_bad = 0;
   logic [15:0] mword = '0;
   logic [11:0] mval = 12'h123;

   always @(negedge adc_cs_n) begin
      logic [3:0] lead;
      falls = 0;
      awake_at_start = awake;
      mval = mval * 12'd13 + 12'h5A7;
      lead = inject ? 4'b0101 : 4'b0000;
      if (!awake)             mword = 16'hFFFF;
      else if (cur_res == 1)  mword = {lead, mval[9:0], 2'b00};
      else if (cur_res == 2)  mword = {lead, mval[7:0], 4'b0000};
      else                    mword = {lead, mval};
      adc_sdata = mword[15];
   end

   always @(negedge adc_sclk) begin
      falls++;
      if (falls < 16) adc_sdata = mword[15 - falls];
   end

   initial begin
      forever begin
         @(posedge adc_cs_n);
         #1;
         if (!in_rst) begin
            if (falls != 16 && falls != 4) len_bad++;
            if (!awake_at_start && falls != 16) dummy_bad++;
            if (falls >= 2 && falls < 10) begin
               awake = 1'b0;
               sd_frames++;
               last_short = 1'b1;
            end else begin
               last_short = 1'b0;
               if (falls >= 10) begin
                  if (awake_at_start && falls == 16) begin
                     exp_t x;
                     if (cur_res == 1)      x.d = {2'b00, mval[9:0]};
                     else if (cur_res == 2) x.d = {4'b0000, mval[7:0]};
                     else                   x.d = mval;
                     x.e = inject;
                     sb_q.push_back(x);
                  end
                  awake = 1'b1;
               end
            end
         end
      end
   end

   // monitor
   int    n_rep = 0;
   int    hi_cnt = 0;
   int    sh_cnt = 0;
   int    sl_cnt = 0;
   int    phase_bad = 0;
   int    ready_bad = 0;
   int    early_cs = 0;
   bit    prev_cs = 1'b1;
   bit    prev_sclk = 1'b0;
   string data_tag = "R9";

   always @(negedge clk) begin
      if (rst_n) begin
         if (smp_valid) begin
            n_rep++;
            if (sb_q.size() == 0) begin
               check(1'b0, "R5", "sample with no good frame", int'(smp_data), 0);
            end else begin
               exp_t x;
               x = sb_q.pop_front();
               check(smp_data == x.d, data_tag, "sample data", int'(smp_data), int'(x.d));
               check(smp_err == x.e, "R10", "lead-bit flag", int'(smp_err), int'(x.e));
            end
         end
         if (!adc_cs_n && req_ready) ready_bad++;
         if (!adc_cs_n && prev_cs && !in_rst) begin
            check(hi_cnt >= QUIET, "R4", "quiet cycles", hi_cnt, QUIET);
            if (last_short)
               check(hi_cnt >= QUIET + cur_ivl, "R7", "idle after shutdown", hi_cnt, QUIET + cur_ivl);
         end
         if (!adc_sclk && prev_sclk && sh_cnt != HALF) phase_bad++;
         if (adc_sclk && !prev_sclk && sl_cnt != HALF) phase_bad++;
      end
      hi_cnt    = adc_cs_n ? hi_cnt + 1 : 0;
      sh_cnt    = adc_sclk ? sh_cnt + 1 : 0;
      sl_cnt    = (!adc_sclk && !adc_cs_n) ? sl_cnt + 1 : 0;
      prev_cs   = adc_cs_n;
      prev_sclk = adc_sclk;
   end

   task automatic do_reset();
      in_rst = 1'b1;
      rst_n  = 1'b0;
      repeat (4) @(negedge clk);
      check(adc_cs_n == 1'b1, "R1", "cs_n in reset", int'(adc_cs_n), 1);
      check(adc_sclk == 1'b0, "R1", "sclk in reset", int'(adc_sclk), 0);
      sb_q.delete();
      awake      = 1'b0;
      last_short = 1'b0;
      inject     = 1'b0;
      rst_n      = 1'b1;
      @(negedge clk);
      in_rst = 1'b0;
   endtask

   task automatic send_req(input bit mode, input int res, input int ivl);
      cur_res = (res == 3) ? 0 : res;
      cur_ivl = ivl;
      @(negedge clk);
      req_mode  = mode;
      req_res   = 2'(res);
      req_ivl   = IVL_W'(ivl);
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_samples(input int n);
      int target;
      target = n_rep + n;
      while (n_rep < target) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int base;
      do_reset();
      check(adc_cs_n == 1'b1, "R1", "cs_n after reset", int'(adc_cs_n), 1);
      check(adc_sclk == 1'b0, "R1", "sclk after reset", int'(adc_sclk), 0);
      check(smp_valid == 1'b0, "R1", "strobe after reset", int'(smp_valid), 0);
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      repeat (60) begin
         @(negedge clk);
         if (!adc_cs_n) early_cs++;
      end
      check(early_cs == 0, "R12", "frames before request", early_cs, 0);

      // continuous, 12-bit
      data_tag = "R8";
      send_req(1'b0, 0, 0);
      wait_samples(5);

      // 10-bit
      do_reset();
      data_tag = "R9";
      send_req(1'b0, 1, 0);
      wait_samples(4);

      // 8-bit
      do_reset();
      send_req(1'b0, 2, 0);
      wait_samples(4);

      // code 3 acts as 12-bit
      do_reset();
      send_req(1'b0, 3, 0);
      wait_samples(3);

      // power-saving bursts
      do_reset();
      data_tag = "R6";
      base = sd_frames;
      send_req(1'b1, 0, 150);
      wait_samples(3);
      check(sd_frames - base >= 2, "R6", "shutdown frames", sd_frames - base, 2);

      // non-zero leading bits
      do_reset();
      data_tag = "R10";
      inject = 1'b1;
      send_req(1'b0, 0, 0);
      wait_samples(3);

      check(dummy_bad == 0, "R5", "short wake frames", dummy_bad, 0);
      check(len_bad == 0, "R3", "frames of wrong length", len_bad, 0);
      check(phase_bad == 0, "R2", "serial clock phase errors", phase_bad, 0);
      check(ready_bad == 0, "R11", "ready during frame", ready_bad, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule